// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the configuration front end of a legacy-style I/O controller. It sits on a simple byte-wide I/O bus and answers at two addresses: an index port and a data port. After reset it is locked. In this state, data-port writes are dropped, and both ports read back 0xFF. Software opens it by writing a four-byte key to the index port. From then on, a byte written to the index port picks a configuration register, and the data port reads or writes that register.

Three kinds of register sit behind the index. Global registers hold the logical-device number, the chip identifier and the revision. Banked registers exist once per logical device and hold that device's enable bit and its 16-bit I/O base. The device number picks which bank is visible. A data write with bit 1 set to the exit index closes configuration mode. Every device's enable bit and base address are driven out continuously to the rest of the chip.

Top module: `sio_cfg_port`

## Requirements
- R1: While reset is asserted and after it is released, the port is locked, the selected device number is 0, every enable output is 0 and every base output is 0x0000.
- R2: Writing 0x87, 0x01, 0x55 and 0x55 in that order to the index port (address 0x2E) enters configuration mode on the cycle after the last byte.
- R3: While locked, an index write that breaks the key restarts matching. If the breaking byte is 0x87, it is taken as the first key byte.
- R4: While locked, data-port (0x2F) writes change nothing, index writes do not load the index, and reads of either port return 0xFF.
- R5: In configuration mode, a read of the index port returns the last index written.
- R6: Index 0x07 holds the logical-device number (low log2(NUM_LDEV) bits), readable back and driven on ldev_sel_o.
- R7: Indices 0x20 and 0x21 read the high and low bytes of the chip ID. Index 0x22 reads the revision in bits 3:0 with bits 7:4 zero. Writes to all three are ignored.
- R8: Index 0x30 is the selected device's enable register: bit 0 is stored and drives that device's ldev_act_o bit, and bits 7:1 read 0.
- R9: Indices 0x60 and 0x61 hold the high and low bytes of the selected device's I/O base, driven on its 16-bit slice of ldev_base_o.
- R10: Banked registers of one device are not affected by writes made while another device is selected. Selecting a device again shows its own stored values.
- R11: A data write to index 0x02 with bit 1 set leaves configuration mode. With bit 1 clear, the port stays open.
- R12: Indices not listed above read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | ADDR_W | I/O address |
| io_wr_i | input | 1 | Write strobe, one cycle per byte |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data for the port at io_addr_i, combinational |
| cfg_mode_o | output | 1 | Configuration mode open |
| ldev_sel_o | output | LDN_W | Selected logical device |
| ldev_act_o | output | NUM_LDEV | Per-device enable |
| ldev_base_o | output | 16*NUM_LDEV | Per-device I/O base, device n in bits 16n+15:16n |

## Verification
The assertions assume that each write strobe lasts exactly one clock cycle and that the address and data are stable while it is high. They also assume that reads need no strobe, because read data follows the address combinationally. The bench always drives inputs on the falling edge and holds a write for one rising edge. It samples read data shortly after setting the address. Key sequences include broken keys and repeated first bytes, so the matcher's restart path is exercised under the same single-cycle strobe rule.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int KEY_LEN = 4;
  localparam logic [8*KEY_LEN-1:0] UNLOCK_KEY = 32'h87_01_55_55;

  localparam logic [7:0] IDX_EXIT    = 8'h02;
  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_ID_HI   = 8'h20;
  localparam logic [7:0] IDX_ID_LO   = 8'h21;
  localparam logic [7:0] IDX_REV     = 8'h22;
  localparam logic [7:0] IDX_ACT     = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;

  function automatic logic [7:0] key_byte(input int unsigned pos);
    return UNLOCK_KEY[8*(KEY_LEN-1-pos) +: 8];
  endfunction
endpackage

// File: rtl/sio_key_match.sv
module sio_key_match
  import sio_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  input  logic       exit_i,
  output logic       unlocked_o
);
  localparam int ST_W = $clog2(KEY_LEN);

  logic [ST_W-1:0] pos_q;
  logic            unlocked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q      <= '0;
      unlocked_q <= 1'b0;
    end else if (unlocked_q) begin
      if (exit_i) unlocked_q <= 1'b0;
      pos_q <= '0;
    end else if (idx_wr_i) begin
      if (wdata_i == key_byte(int'(pos_q))) begin
        if (int'(pos_q) == KEY_LEN-1) begin
          unlocked_q <= 1'b1;
          pos_q      <= '0;
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end else if (wdata_i == key_byte(0)) begin
        pos_q <= ST_W'(1);  // mismatching byte may itself open a new key
      end else begin
        pos_q <= '0;
      end
    end
  end

  assign unlocked_o = unlocked_q;
endmodule

// File: rtl/sio_ldev_bank.sv
module sio_ldev_bank (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        act_we_i,
  input  logic        base_hi_we_i,
  input  logic        base_lo_we_i,
  input  logic [7:0]  wdata_i,
  output logic        act_o,
  output logic [15:0] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o  <= 1'b0;
      base_o <= '0;
    end else begin
      if (act_we_i)     act_o         <= wdata_i[0];
      if (base_hi_we_i) base_o[15:8]  <= wdata_i;
      if (base_lo_we_i) base_o[7:0]   <= wdata_i;
    end
  end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] INDEX_ADDR = 16'h002E,
  parameter logic [15:0] DATA_ADDR  = 16'h002F,
  parameter int          NUM_LDEV   = 8,
  parameter logic [15:0] CHIP_ID    = 16'hC3A5,
  parameter logic [3:0]  CHIP_REV   = 4'h6,
  localparam int         LDN_W      = $clog2(NUM_LDEV)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      io_addr_i,
  input  logic                   io_wr_i,
  input  logic [7:0]             io_wdata_i,
  output logic [7:0]             io_rdata_o,
  output logic                   cfg_mode_o,
  output logic [LDN_W-1:0]       ldev_sel_o,
  output logic [NUM_LDEV-1:0]    ldev_act_o,
  output logic [16*NUM_LDEV-1:0] ldev_base_o
);
  logic            at_index, at_data;
  logic            unlocked;
  logic            idx_wr, data_wr, exit_req;
  logic [7:0]      index_q;
  logic [LDN_W-1:0] ldn_q;
  logic [15:0]     base_arr [NUM_LDEV];

  assign at_index = (io_addr_i == ADDR_W'(INDEX_ADDR));
  assign at_data  = (io_addr_i == ADDR_W'(DATA_ADDR));
  assign idx_wr   = io_wr_i && at_index;
  assign data_wr  = io_wr_i && at_data && unlocked;
  assign exit_req = data_wr && (index_q == IDX_EXIT) && io_wdata_i[1];

  sio_key_match u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_wr_i   (idx_wr),
    .wdata_i    (io_wdata_i),
    .exit_i     (exit_req),
    .unlocked_o (unlocked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_q <= '0;
      ldn_q   <= '0;
    end else begin
      if (idx_wr && unlocked) index_q <= io_wdata_i;
      if (data_wr && index_q == IDX_LDN) ldn_q <= io_wdata_i[LDN_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_LDEV; g++) begin : g_bank
    logic sel;
    assign sel = (ldn_q == LDN_W'(g));
    sio_ldev_bank u_bank (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .act_we_i     (data_wr && sel && index_q == IDX_ACT),
      .base_hi_we_i (data_wr && sel && index_q == IDX_BASE_HI),
      .base_lo_we_i (data_wr && sel && index_q == IDX_BASE_LO),
      .wdata_i      (io_wdata_i),
      .act_o        (ldev_act_o[g]),
      .base_o       (base_arr[g])
    );
    assign ldev_base_o[16*g +: 16] = base_arr[g];
  end

  always_comb begin
    io_rdata_o = 8'hFF;
    if (unlocked && at_index) begin
      io_rdata_o = index_q;
    end else if (unlocked && at_data) begin
      case (index_q)
        IDX_LDN:     io_rdata_o = 8'(ldn_q);
        IDX_ID_HI:   io_rdata_o = CHIP_ID[15:8];
        IDX_ID_LO:   io_rdata_o = CHIP_ID[7:0];
        IDX_REV:     io_rdata_o = {4'h0, CHIP_REV};
        IDX_ACT:     io_rdata_o = {7'h00, ldev_act_o[ldn_q]};
        IDX_BASE_HI: io_rdata_o = base_arr[ldn_q][15:8];
        IDX_BASE_LO: io_rdata_o = base_arr[ldn_q][7:0];
        default:     io_rdata_o = 8'h00;
      endcase
    end
  end

  assign cfg_mode_o = unlocked;
  assign ldev_sel_o = ldn_q;
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] INDEX_ADDR = 16'h002E,
  parameter logic [15:0] DATA_ADDR  = 16'h002F,
  parameter int          NUM_LDEV   = 8,
  parameter int          LDN_W      = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [ADDR_W-1:0]      io_addr_i,
  input logic                   io_wr_i,
  input logic [7:0]             io_wdata_i,
  input logic [7:0]             io_rdata_o,
  input logic                   cfg_mode_o,
  input logic [LDN_W-1:0]       ldev_sel_o,
  input logic [NUM_LDEV-1:0]    ldev_act_o,
  input logic [16*NUM_LDEV-1:0] ldev_base_o,
  input logic [7:0]             index_q
);
  logic at_idx, at_dat;
  assign at_idx = (io_addr_i == ADDR_W'(INDEX_ADDR));
  assign at_dat = (io_addr_i == ADDR_W'(DATA_ADDR));

  a_r4_locked_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_mode_o && io_wr_i && at_dat) |=>
      ($stable(ldev_act_o) && $stable(ldev_base_o) && $stable(ldev_sel_o)));

  a_r4_locked_read_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_mode_o && (at_dat || at_idx)) |-> (io_rdata_o == 8'hFF));

  a_r2_open_after_key_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_mode_o) |-> $past(io_wr_i && at_idx && io_wdata_i == 8'h55));

  a_r11_exit_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_o && io_wr_i && at_dat && index_q == 8'h02 && io_wdata_i[1]) |=> !cfg_mode_o);

  a_r8_act_frozen_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_mode_o |=> $stable(ldev_act_o));

  a_r6_sel_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldev_sel_o != $past(ldev_sel_o)) |->
      $past(cfg_mode_o && io_wr_i && at_dat && index_q == 8'h07));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .ADDR_W(ADDR_W), .INDEX_ADDR(INDEX_ADDR), .DATA_ADDR(DATA_ADDR),
  .NUM_LDEV(NUM_LDEV), .LDN_W(LDN_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .io_addr_i(io_addr_i), .io_wr_i(io_wr_i),
  .io_wdata_i(io_wdata_i), .io_rdata_o(io_rdata_o), .cfg_mode_o(cfg_mode_o),
  .ldev_sel_o(ldev_sel_o), .ldev_act_o(ldev_act_o), .ldev_base_o(ldev_base_o),
  .index_q(index_q)
);

// File: tb/sio_cfg_port_bench.sv
module sio_cfg_port_bench;
  localparam int NL = 8;
  localparam logic [15:0] IDX_A = 16'h002E;
  localparam logic [15:0] DAT_A = 16'h002F;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [15:0]   io_addr_i = '0;
  logic          io_wr_i = 1'b0;
  logic [7:0]    io_wdata_i = '0;
  logic [7:0]    io_rdata_o;
  logic          cfg_mode_o;
  logic [2:0]    ldev_sel_o;
  logic [NL-1:0] ldev_act_o;
  logic [16*NL-1:0] ldev_base_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  sio_cfg_port #(.NUM_LDEV(NL), .CHIP_ID(16'hC3A5), .CHIP_REV(4'h6)) u_sio_cfg_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .io_addr_i(io_addr_i), .io_wr_i(io_wr_i),
    .io_wdata_i(io_wdata_i), .io_rdata_o(io_rdata_o), .cfg_mode_o(cfg_mode_o),
    .ldev_sel_o(ldev_sel_o), .ldev_act_o(ldev_act_o), .ldev_base_o(ldev_base_o)
  );

  // entry = {req, op, value, expected}; op 0 idx wr, 1 data wr, 2 idx rd, 3 data rd
  localparam int NVEC = 56;
  localparam logic [23:0] VEC [NVEC] = '{
    24'h4_3_00_FF, 24'h4_2_00_FF, 24'h4_0_07_00, 24'h4_1_05_00,   // R4 locked
    24'h2_0_87_00, 24'h2_0_01_00, 24'h2_0_55_00, 24'h2_0_55_00,   // R2 key
    24'h5_2_00_00, 24'h5_0_07_00, 24'h4_3_00_00, 24'h5_2_00_07,   // R5, R4 ldn kept 0
    24'h7_0_20_00, 24'h7_3_00_C3, 24'h7_0_21_00, 24'h7_3_00_A5,   // R7
    24'h7_0_22_00, 24'h7_3_00_06, 24'h7_1_55_00, 24'h7_3_00_06,
    24'h6_0_07_00, 24'h6_1_03_00, 24'h6_3_00_03,                  // R6
    24'h8_0_30_00, 24'h8_1_FF_00, 24'h8_3_00_01,                  // R8
    24'h9_0_60_00, 24'h9_1_12_00, 24'h9_3_00_12,                  // R9
    24'h9_0_61_00, 24'h9_1_34_00, 24'h9_3_00_34,
    24'hA_0_07_00, 24'hA_1_05_00, 24'hA_0_30_00, 24'hA_3_00_00,   // R10
    24'hA_0_60_00, 24'hA_3_00_00, 24'hA_1_AB_00, 24'hA_0_07_00,
    24'hA_1_03_00, 24'hA_0_60_00, 24'hA_3_00_12, 24'hA_0_61_00,
    24'hA_3_00_34, 24'hA_0_30_00, 24'hA_3_00_01,
    24'hC_0_45_00, 24'hC_1_77_00, 24'hC_3_00_00,                  // R12
    24'hB_0_02_00, 24'hB_1_01_00, 24'hB_2_00_02, 24'hB_1_02_00,   // R11
    24'hB_3_00_FF, 24'hB_2_00_FF
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    io_addr_i = a; io_wdata_i = d; io_wr_i = 1'b1;
    @(negedge clk_i);
    io_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk_i);
    io_addr_i = a;
    #1 d = io_rdata_o;
  endtask

  task automatic key(input logic [7:0] b0, b1, b2, b3, b4, b5, input int n);
    logic [7:0] seq [6];
    seq = '{b0, b1, b2, b3, b4, b5};
    for (int i = 0; i < n; i++) wr(IDX_A, seq[i]);
  endtask

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk_i);
    check("R1 cfg", 16'(cfg_mode_o), 16'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 sel", 16'(ldev_sel_o), 16'h0);
    check("R1 act", 16'(ldev_act_o), 16'h0);
    check("R1 base", 16'(|ldev_base_o), 16'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [3:0] rq, op;
      logic [7:0] v, e;
      {rq, op, v, e} = VEC[i];
      case (op)
        4'd0: wr(IDX_A, v);
        4'd1: wr(DAT_A, v);
        4'd2: begin rd(IDX_A, r); check($sformatf("R%0d vec %0d", rq, i), 16'(r), 16'(e)); end
        default: begin rd(DAT_A, r); check($sformatf("R%0d vec %0d", rq, i), 16'(r), 16'(e)); end
      endcase
    end

    // R8 R9 R10 at the output pins
    check("R8 act pins", 16'(ldev_act_o), 16'h0008);
    check("R9 base dev3", ldev_base_o[3*16 +: 16], 16'h1234);
    check("R10 base dev5", ldev_base_o[5*16 +: 16], 16'hAB00);
    check("R11 closed", 16'(cfg_mode_o), 16'h0);

    // R4 locked writes leave pins untouched
    wr(IDX_A, 8'h30); wr(DAT_A, 8'h00);
    @(negedge clk_i);
    check("R4 act kept", 16'(ldev_act_o), 16'h0008);

    // R3 wrong byte restarts, 0x87 re-seeds
    key(8'h87, 8'h01, 8'h87, 8'h01, 8'h55, 8'h55, 6);
    @(negedge clk_i);
    check("R3 reseed open", 16'(cfg_mode_o), 16'h1);
    wr(IDX_A, 8'h02); wr(DAT_A, 8'h02);
    @(negedge clk_i);
    check("R11 exit", 16'(cfg_mode_o), 16'h0);
    key(8'h87, 8'h01, 8'h55, 8'hAA, 8'h55, 8'h00, 5);
    @(negedge clk_i);
    check("R3 broken key", 16'(cfg_mode_o), 16'h0);
    key(8'h87, 8'h87, 8'h01, 8'h55, 8'h55, 8'h00, 5);
    @(negedge clk_i);
    check("R3 double first", 16'(cfg_mode_o), 16'h1);

    // R1 reset mid-run
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 rst cfg", 16'(cfg_mode_o), 16'h0);
    check("R1 rst act", 16'(ldev_act_o), 16'h0);
    check("R1 rst base", 16'(|ldev_base_o), 16'h0);
    rst_ni = 1'b1;
    rd(DAT_A, r);
    check("R4 rst read", 16'(r), 16'h00FF);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule